// File: doc/BRIEF.md
# Programmable 16-bit Counter/Timer with Coherent Byte Reads

This block is a 16-bit free-running up-counter clocked by the system clock. It advances by one on each enable pulse from a timebase that software selects from eight sources: two fixed prescalers of the system clock, the system clock itself, falling edges of an asynchronous external count pin, rising edges of an external oscillator already divided by eight, and overflow pulses from three neighbouring timers. Counting is gated by a run bit, and an optional idle-stop bit freezes it while the CPU reports idle.

The CPU sees the block as four byte registers selected by a 2-bit address. A read of the low count byte captures the high byte into a holding register, and a later high-byte read returns that captured value, so a low-then-high read sequence is coherent while the counter runs. When the count wraps from 0xFFFF to 0x0000 a sticky overflow flag is set, a one-cycle overflow pulse goes to downstream logic, and an interrupt request is raised when enabled. Only software clears the flag.

Top module: `snap_timer`

## Requirements
- R1: Register address 0 is the count low byte, 1 the high-byte holding register, 2 the mode register, 3 the control register; after reset every register reads 0, the count is 0 and irqReq is 0.
- R2: A read of address 0 (rdEn high) copies the current count high byte into the holding register on that clock edge; a read of address 1 returns the holding register, not the live high byte.
- R3: Mode bits [3:1] select the timebase: 0 = clock/12, 1 = clock/4, 2 = t0Ovf pulses, 3 = external pin falling edges, 4 = every clock, 5 = external oscillator/8 rising edges, 6 = t4Ovf pulses, 7 = t5Ovf pulses.
- R4: extCountIn passes through a two-flop synchroniser and each high-to-low transition yields exactly one count; the pin may toggle at most at clock/4.
- R5: extOscDiv8 is synchronised by two flops and each rising edge yields exactly one count.
- R6: Control bit 0 is the run bit; with it at 0 the count holds; register reads never change the count.
- R7: Mode bit 7 is idle-stop: when 1 and cpuIdle is high the count holds; when 0 counting continues during idle.
- R8: A count step from 0xFFFF to 0x0000 sets the overflow flag (control bit 7) and drives ovfPulse high for exactly the following cycle.
- R9: irqReq is high whenever the overflow flag is 1 and mode bit 0 (interrupt enable) is 1.
- R10: The overflow flag is cleared only by a control write with bit 7 = 0; a write with bit 7 = 1 leaves it, and a wrap in the same cycle as a clearing write leaves it set.
- R11: Writes to address 0 or 1 load that count byte directly, and no count step happens in a cycle with such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register address |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdEn | input | 1 | Register read strobe |
| rdData | output | 8 | Register read data for regSel |
| cpuIdle | input | 1 | CPU idle indication |
| extCountIn | input | 1 | Asynchronous external count pin |
| extOscDiv8 | input | 1 | Asynchronous external oscillator divided by eight |
| t0Ovf | input | 1 | Timer 0 overflow pulse |
| t4Ovf | input | 1 | Timer 4 overflow pulse |
| t5Ovf | input | 1 | Timer 5 overflow pulse |
| countValue | output | 16 | Live count for compare logic |
| ovfPulse | output | 1 | One-cycle wrap pulse |
| irqReq | output | 1 | Overflow interrupt request |

## Verification
A wrong timebase selection or a prescaler phase error shows as a wrong count delta after a fixed window of cycles, visible on countValue within one window of 25 to 120 cycles. A holding register that captures on the wrong edge or never captures shows on the first high-byte read after the live high byte is rewritten. A flag that is not sticky or loses the priority race shows on the control register and irqReq one cycle after the wrap, and a gating fault shows as a count that moves during a stopped or idle interval of ten cycles.

// File: rtl/snap_timer_pkg.sv
package snap_timer_pkg;
  localparam int BYTE_W = 8;
  localparam int COUNT_W = 2 * BYTE_W;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic              tick;
    logic              loadLo;
    logic              loadHi;
    logic              capSnap;
    logic              clrFlag;
    logic [BYTE_W-1:0] wrByte;
  } dpStrobes_t;
endpackage

// File: rtl/snap_timer_edge.sv
module snap_timer_edge #(
  parameter int SYNC_STAGES = 2,
  parameter bit FALLING     = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic edgePulse
);
  localparam logic [SYNC_STAGES:0] RESET_VAL = FALLING ? '1 : '0;

  logic [SYNC_STAGES:0] pipe;
  logic syncVal;
  logic prevVal;

  always_ff @(posedge clk) begin
    if (!rstN) pipe <= RESET_VAL;
    else       pipe <= {pipe[SYNC_STAGES-1:0], asyncIn};
  end

  assign syncVal = pipe[SYNC_STAGES-1];
  assign prevVal = pipe[SYNC_STAGES];

  generate
    if (FALLING) begin : g_fall
      assign edgePulse = prevVal & ~syncVal;
    end else begin : g_rise
      assign edgePulse = ~prevVal & syncVal;
    end
  endgenerate
endmodule

// File: rtl/snap_timer_tbase.sv
module snap_timer_tbase #(
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] srcSel,
  input  logic       extCountIn,
  input  logic       extOscDiv8,
  input  logic       t0Ovf,
  input  logic       t4Ovf,
  input  logic       t5Ovf,
  output logic       srcPulse
);
  localparam int SLOW_W = $clog2(DIV_SLOW);
  localparam int FAST_W = $clog2(DIV_FAST);
  localparam logic [SLOW_W-1:0] SLOW_LAST = SLOW_W'(DIV_SLOW - 1);
  localparam logic [FAST_W-1:0] FAST_LAST = FAST_W'(DIV_FAST - 1);

  logic [SLOW_W-1:0] slowCnt;
  logic [FAST_W-1:0] fastCnt;
  logic slowPulse, fastPulse, pinFall, oscRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slowCnt <= '0;
      fastCnt <= '0;
    end else begin
      slowCnt <= (slowCnt == SLOW_LAST) ? '0 : slowCnt + 1'b1;
      fastCnt <= (fastCnt == FAST_LAST) ? '0 : fastCnt + 1'b1;
    end
  end

  assign slowPulse = (slowCnt == SLOW_LAST);
  assign fastPulse = (fastCnt == FAST_LAST);

  snap_timer_edge #(.SYNC_STAGES(SYNC_STAGES), .FALLING(1'b1)) u_pinEdge (
    .clk(clk), .rstN(rstN), .asyncIn(extCountIn), .edgePulse(pinFall)
  );

  snap_timer_edge #(.SYNC_STAGES(SYNC_STAGES), .FALLING(1'b0)) u_oscEdge (
    .clk(clk), .rstN(rstN), .asyncIn(extOscDiv8), .edgePulse(oscRise)
  );

  always_comb begin
    unique case (srcSel)
      3'd0:    srcPulse = slowPulse;
      3'd1:    srcPulse = fastPulse;
      3'd2:    srcPulse = t0Ovf;
      3'd3:    srcPulse = pinFall;
      3'd4:    srcPulse = 1'b1;
      3'd5:    srcPulse = oscRise;
      3'd6:    srcPulse = t4Ovf;
      default: srcPulse = t5Ovf;
    endcase
  end
endmodule

// File: rtl/snap_timer_ctrl.sv
module snap_timer_ctrl
  import snap_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              cpuIdle,
  input  logic              srcPulse,
  input  logic [BYTE_W-1:0] countLo,
  input  logic [BYTE_W-1:0] snapHi,
  input  logic              ovfFlag,
  output dpStrobes_t        strobes,
  output logic [2:0]        srcSel,
  output logic              irqEn,
  output logic              runBit,
  output logic              idleStop,
  output logic [BYTE_W-1:0] rdData
);
  logic wrLo, wrHi, wrMode, wrCtrl, gateOpen;

  assign wrLo   = wrEn && (regSel == ADDR_LO);
  assign wrHi   = wrEn && (regSel == ADDR_HI);
  assign wrMode = wrEn && (regSel == ADDR_MODE);
  assign wrCtrl = wrEn && (regSel == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel   <= '0;
      irqEn    <= 1'b0;
      idleStop <= 1'b0;
      runBit   <= 1'b0;
    end else begin
      if (wrMode) begin
        idleStop <= wrData[7];
        srcSel   <= wrData[3:1];
        irqEn    <= wrData[0];
      end
      if (wrCtrl) runBit <= wrData[0];
    end
  end

  assign gateOpen = runBit && !(idleStop && cpuIdle);

  always_comb begin
    strobes.tick    = srcPulse && gateOpen && !wrLo && !wrHi;
    strobes.loadLo  = wrLo;
    strobes.loadHi  = wrHi;
    strobes.capSnap = rdEn && (regSel == ADDR_LO);
    strobes.clrFlag = wrCtrl && !wrData[7];
    strobes.wrByte  = wrData;
  end

  always_comb begin
    unique case (regSel)
      ADDR_LO:   rdData = countLo;
      ADDR_HI:   rdData = snapHi;
      ADDR_MODE: rdData = {idleStop, 3'b000, srcSel, irqEn};
      default:   rdData = {ovfFlag, 6'b000000, runBit};
    endcase
  end
endmodule

// File: rtl/snap_timer_dp.sv
module snap_timer_dp
  import snap_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strobes,
  output logic [COUNT_W-1:0] count,
  output logic [BYTE_W-1:0]  snapHi,
  output logic               ovfFlag,
  output logic               ovfPulse
);
  logic wrap;

  assign wrap = strobes.tick && (count == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      snapHi   <= '0;
      ovfFlag  <= 1'b0;
      ovfPulse <= 1'b0;
    end else begin
      if (strobes.loadLo) count[BYTE_W-1:0] <= strobes.wrByte;
      if (strobes.loadHi) count[COUNT_W-1:BYTE_W] <= strobes.wrByte;
      if (strobes.tick)   count <= count + 1'b1;
      if (strobes.capSnap) snapHi <= count[COUNT_W-1:BYTE_W];
      // hardware set outranks software clear
      if (wrap)                 ovfFlag <= 1'b1;
      else if (strobes.clrFlag) ovfFlag <= 1'b0;
      ovfPulse <= wrap;
    end
  end
endmodule

// File: rtl/snap_timer.sv
module snap_timer
  import snap_timer_pkg::*;
#(
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   regSel,
  input  logic         wrEn,
  input  logic [7:0]   wrData,
  input  logic         rdEn,
  output logic [7:0]   rdData,
  input  logic         cpuIdle,
  input  logic         extCountIn,
  input  logic         extOscDiv8,
  input  logic         t0Ovf,
  input  logic         t4Ovf,
  input  logic         t5Ovf,
  output logic [15:0]  countValue,
  output logic         ovfPulse,
  output logic         irqReq
);
  dpStrobes_t        strobes;
  logic [2:0]        srcSel;
  logic              srcPulse, irqEn, runBit, idleStop, ovfFlag;
  logic [BYTE_W-1:0] snapHi;

  snap_timer_tbase #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .SYNC_STAGES(SYNC_STAGES)) u_tbase (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .extCountIn(extCountIn),
    .extOscDiv8(extOscDiv8), .t0Ovf(t0Ovf), .t4Ovf(t4Ovf), .t5Ovf(t5Ovf),
    .srcPulse(srcPulse)
  );

  snap_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .cpuIdle(cpuIdle), .srcPulse(srcPulse),
    .countLo(countValue[BYTE_W-1:0]), .snapHi(snapHi), .ovfFlag(ovfFlag),
    .strobes(strobes), .srcSel(srcSel), .irqEn(irqEn), .runBit(runBit),
    .idleStop(idleStop), .rdData(rdData)
  );

  snap_timer_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .count(countValue),
    .snapHi(snapHi), .ovfFlag(ovfFlag), .ovfPulse(ovfPulse)
  );

  assign irqReq = ovfFlag && irqEn;
endmodule

// File: rtl/snap_timer_chk.sv
module snap_timer_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] count,
  input logic [7:0]  snapHi,
  input logic        ovfFlag,
  input logic        ovfPulse,
  input logic        tick,
  input logic        loadAny,
  input logic        clrFlag,
  input logic        rdLo,
  input logic        runBit,
  input logic        idleStop,
  input logic        cpuIdle
);
  p_run_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !loadAny) |=> $stable(count));

  p_idle_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    (idleStop && cpuIdle && !loadAny) |=> $stable(count));

  p_wrap_sets_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tick && count == 16'hFFFF) |=> (ovfFlag && ovfPulse && count == 16'h0000));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> !ovfPulse);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrFlag) |=> ovfFlag);

  p_snap_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdLo |=> (snapHi == $past(count[15:8])));
endmodule

bind snap_timer snap_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .count(countValue), .snapHi(snapHi),
  .ovfFlag(ovfFlag), .ovfPulse(ovfPulse), .tick(strobes.tick),
  .loadAny(strobes.loadLo | strobes.loadHi), .clrFlag(strobes.clrFlag),
  .rdLo(strobes.capSnap), .runBit(runBit), .idleStop(idleStop), .cpuIdle(cpuIdle)
);

// File: tb/tb_snap_timer.sv
module tb_snap_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_MODE = 2'd2, A_CTRL = 2'd3;
  // {source select, window cycles, expected counts}
  localparam int unsigned VEC [0:7][0:2] = '{
    '{0, 120, 10}, '{1, 40, 10}, '{2, 30, 10}, '{3, 40, 10},
    '{4, 25, 25},  '{5, 40, 5},  '{6, 30, 6},  '{7, 30, 5}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] regSel = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, cpuIdle = 1'b0;
  logic [7:0] wrData = '0, rdData;
  logic extCountIn = 1'b1, extOscDiv8 = 1'b0, t0Ovf = 1'b0, t4Ovf = 1'b0, t5Ovf = 1'b0;
  logic [15:0] countValue;
  logic ovfPulse, irqReq;

  int nChecks = 0, nFail = 0, pulseCnt = 0, phase = 0;

  snap_timer dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      phase++;
      t0Ovf = (phase % 3 == 0);
      t4Ovf = (phase % 5 == 0);
      t5Ovf = (phase % 6 == 0);
      extCountIn = phase[1];
      extOscDiv8 = phase[2];
      if (ovfPulse) pulseCnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regSel = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regSel = a; rdEn = 1'b1;
    #1 d = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] lo, hi, v;
    logic [15:0] c1, c2;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(A_LO, v);   check("R1 lo", v, 0);
    rd(A_HI, v);   check("R1 hi", v, 0);
    rd(A_MODE, v); check("R1 mode", v, 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    check("R1 irq", irqReq, 0);

    // R3 R4 R5 table of timebase windows
    for (int i = 0; i < 8; i++) begin
      wr(A_CTRL, 8'h00);
      wr(A_LO, 8'h00);
      wr(A_HI, 8'h00);
      wr(A_MODE, {4'b0000, 3'(VEC[i][0]), 1'b0});
      wr(A_CTRL, 8'h01);
      repeat (VEC[i][1] - 1) @(posedge clk);
      wr(A_CTRL, 8'h00);
      rd(A_LO, lo); rd(A_HI, hi);
      check($sformatf("R3 sel%0d (R4 R5)", VEC[i][0]), {hi, lo}, VEC[i][2]);
    end

    // R2 snapshot holds while live high byte changes
    wr(A_LO, 8'hFF); wr(A_HI, 8'h12);
    rd(A_LO, v);  check("R2 lo", v, 8'hFF);
    wr(A_HI, 8'h34);
    rd(A_HI, v);  check("R2 snap", v, 8'h12);
    rd(A_LO, v);  rd(A_HI, v); check("R2 recapture", v, 8'h34);

    // R11 write wins over step
    wr(A_MODE, 8'h08);
    wr(A_LO, 8'hFE); wr(A_HI, 8'h00);
    wr(A_CTRL, 8'h01);
    wr(A_LO, 8'h50);
    check("R11 load", countValue, 16'h0050);

    // R6 reads do not disturb counting
    c1 = countValue;
    for (int k = 0; k < 5; k++) rd(A_LO, v);
    check("R6 reads", countValue - c1, 5);
    wr(A_CTRL, 8'h00);
    c1 = countValue; repeat (10) @(posedge clk); #1;
    check("R6 stopped", countValue, c1);

    // R8 R9 overflow
    wr(A_MODE, 8'h09);
    wr(A_LO, 8'hFE); wr(A_HI, 8'hFF);
    pulseCnt = 0;
    wr(A_CTRL, 8'h01);
    @(posedge clk); @(posedge clk); #1;
    check("R8 wrap", countValue, 0);
    check("R8 pulse", ovfPulse, 1);
    check("R9 irq", irqReq, 1);
    wr(A_CTRL, 8'h80);
    check("R8 single pulse", pulseCnt, 1);
    rd(A_CTRL, v); check("R10 sticky", v, 8'h80);
    wr(A_MODE, 8'h08); check("R9 masked", irqReq, 0);
    rd(A_CTRL, v); check("R9 flag kept", v, 8'h80);
    wr(A_MODE, 8'h09); check("R9 unmasked", irqReq, 1);
    wr(A_CTRL, 8'h00);
    rd(A_CTRL, v); check("R10 cleared", v, 8'h00);
    check("R10 irq low", irqReq, 0);

    // R7 idle freeze, then R10 set beats clear
    wr(A_MODE, 8'h89);
    @(negedge clk) cpuIdle = 1'b1;
    wr(A_LO, 8'hFF); wr(A_HI, 8'hFF);
    wr(A_CTRL, 8'h01);
    repeat (5) @(posedge clk); #1;
    check("R7 frozen", countValue, 16'hFFFF);
    @(negedge clk);
    cpuIdle = 1'b0; regSel = A_CTRL; wrData = 8'h01; wrEn = 1'b1;
    @(posedge clk); #1 wrEn = 1'b0;
    check("R10 priority count", countValue, 0);
    rd(A_CTRL, v); check("R10 priority flag", v, 8'h81);

    // R7 idle without idle-stop keeps counting
    wr(A_MODE, 8'h09);
    @(negedge clk) cpuIdle = 1'b1;
    @(posedge clk); #1 c1 = countValue;
    repeat (10) @(posedge clk); #1 c2 = countValue;
    check("R7 idle counting", c2 - c1, 10);
    cpuIdle = 1'b0;
    wr(A_CTRL, 8'h00);

    finishRun();
  end
endmodule